// File: doc/BRIEF.md
# Microcoded Memory Bus Sequencer

This block drives the control strobes of an external memory bus from a small writable microcode table. Each table word fixes the chip-select, byte-select and general-purpose output levels for one bus clock. The two select lines carry four phase bits per word, so their edges can be placed on any quarter of the bus clock period. A sequence is started by one of four sources: a memory access, a periodic timer such as a refresh, an exception, or a software run command. Each source has its own programmable start index. From that index the sequencer fetches one word per cycle and stops after a word with the last bit set. A word can also ask to stall on an external wait input.

Software loads the table and the start indices while the sequencer is idle. Requesters raise their request while the sequencer is idle. A request that arrives while a sequence runs is not queued, so the requester must present it again after `done`. The sequencer does not step any address, so the address stays the same for a whole burst. The address path itself lies outside this block. A quarter-phase select input picks which phase bit of the current word appears on the serial select lines.

Top module: `ucode_bus_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle, `cs_ph` and `bs_ph` read 4'hF and `cs_line`/`bs_line` read 1. After reset, `gpo`, `busy`, `done` and `wr_err` read 0 and the start indices take their reset values (R3).
- R2: While busy, the fields of the word at `seq_idx` drive the outputs: bits [31:28] go to `cs_ph`, bits [27:24] go to `bs_ph` and bits [23:20] go to `gpo`. Bit 1 is wait-enable and bit 0 is last.
- R3: A start loads `seq_idx` with the start index of the granted source, and `busy` rises on the same edge. Source codes are memory 0, timer 1, exception 2 and run 3. A write with `cfg_we` sets the index of source `cfg_src`. The reset values are 0, 16, 32 and 48 for codes 0 to 3.
- R4: When several requests are present while idle, the grant goes to exception first, then run, then timer, then memory. `active_src` shows the code of the granted source while busy.
- R5: While busy and not stalled, `seq_idx` goes up by one on each edge after a word whose last bit is 0.
- R6: After a word whose last bit is 1 has been presented for one cycle, `busy` falls and `done` is high for exactly that one following cycle.
- R7: A word with wait-enable set is held at edge n when `wait_in` was high at edge n-2. While it is held, its outputs stay unchanged.
- R8: A word with wait-enable clear is never held, whatever `wait_in` is.
- R9: A table write while busy is dropped, the stored word keeps its old value, and `wr_err` goes to 1 and stays there until reset. A write while idle updates the table.
- R10: Requests while busy do not change `active_src` or `seq_idx`, and they do not start a sequence later.
- R11: `cs_line` equals `cs_ph[3-qsel]` and `bs_line` equals `bs_ph[3-qsel]`. Quarter 0 is bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_mem | input | 1 | Memory access request |
| req_tmr | input | 1 | Periodic timer request |
| req_exc | input | 1 | Exception request |
| req_run | input | 1 | Software run command |
| cfg_we | input | 1 | Start index write strobe |
| cfg_src | input | 2 | Source code whose start index is written |
| cfg_idx | input | 6 | New start index |
| uc_we | input | 1 | Microcode write strobe |
| uc_addr | input | 6 | Microcode write address |
| uc_wdata | input | 32 | Microcode write word |
| wait_in | input | 1 | External wait, asynchronous |
| qsel | input | 2 | Quarter-phase select for the serial lines |
| busy | output | 1 | Sequence running |
| active_src | output | 2 | Code of the granted source |
| seq_idx | output | 6 | Current microcode index |
| cs_ph | output | 4 | Chip-select phase bits of the current word |
| bs_ph | output | 4 | Byte-select phase bits of the current word |
| gpo | output | 4 | General-purpose outputs |
| cs_line | output | 1 | Chip-select level in quarter `qsel` |
| bs_line | output | 1 | Byte-select level in quarter `qsel` |
| done | output | 1 | One-cycle end-of-sequence pulse |
| wr_err | output | 1 | Sticky flag for a dropped table write |

## Verification
A request that is present at an edge shows up as `busy`, `seq_idx` and the first word's outputs right after that edge, so the bench samples one cycle after it drives the request. The index then advances one word per cycle. `done` appears in the cycle after the last word, and the bench follows this with a cycle-by-cycle model of the index. The wait input acts on the decision two edges later, so the bench raises wait two cycles before a start to see the hold from the first word. After it drops wait, it expects the index to move on the third edge. The serial lines and the `wr_err` flag are combinational or one edge away, and the bench checks them in the cycle after the stimulus.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
    localparam int UW_W = 32;

    typedef enum logic [1:0] {
        SRC_MEM = 2'd0,
        SRC_TMR = 2'd1,
        SRC_EXC = 2'd2,
        SRC_RUN = 2'd3
    } src_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    typedef struct packed {
        logic [3:0]  cs;
        logic [3:0]  bs;
        logic [3:0]  gpo;
        logic [17:0] rsv;
        logic        wen;
        logic        last;
    } uword_t;

    // grant order, lowest priority first; later entries override earlier ones
    localparam src_e PRIO_LOW_FIRST [4] = '{SRC_MEM, SRC_TMR, SRC_RUN, SRC_EXC};

    function automatic logic [5:0] reset_start(input int src);
        return 6'(src * 16);
    endfunction

    function automatic logic phase_bit(input logic [3:0] ph, input logic [1:0] q);
        return ph[2'd3 - q];
    endfunction
endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
    parameter int IDX_W = 6,
    parameter int DAT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DAT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DAT_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DAT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ucseq_arb.sv
module ucseq_arb
    import ucseq_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int NSRC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_src,
    input  logic [IDX_W-1:0] cfg_idx,
    output logic             any,
    output src_e             win,
    output logic [IDX_W-1:0] win_idx
);
    logic [IDX_W-1:0] start_tbl [NSRC];

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_tbl
            always_ff @(posedge clk) begin
                if (rst)
                    start_tbl[s] <= IDX_W'(reset_start(s));
                else if (cfg_we && cfg_src == 2'(s))
                    start_tbl[s] <= cfg_idx;
            end
        end
    endgenerate

    always_comb begin
        any = |req;
        win = SRC_MEM;
        for (int p = 0; p < NSRC; p++) begin
            if (req[PRIO_LOW_FIRST[p]]) win = PRIO_LOW_FIRST[p];
        end
        win_idx = start_tbl[win];
    end
endmodule

// File: rtl/ucseq_wsync.sv
module ucseq_wsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/ucode_bus_seq.sv
module ucode_bus_seq
    import ucseq_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_mem,
    input  logic             req_tmr,
    input  logic             req_exc,
    input  logic             req_run,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_src,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             uc_we,
    input  logic [IDX_W-1:0] uc_addr,
    input  logic [31:0]      uc_wdata,
    input  logic             wait_in,
    input  logic [1:0]       qsel,
    output logic             busy,
    output logic [1:0]       active_src,
    output logic [IDX_W-1:0] seq_idx,
    output logic [3:0]       cs_ph,
    output logic [3:0]       bs_ph,
    output logic [3:0]       gpo,
    output logic             cs_line,
    output logic             bs_line,
    output logic             done,
    output logic             wr_err
);
    localparam int NSRC = 4;

    st_e              state;
    src_e             src_q;
    logic [IDX_W-1:0] idx_q;
    logic [UW_W-1:0]  rdata;
    uword_t           word;
    logic             any_req;
    src_e             win;
    logic [IDX_W-1:0] win_idx;
    logic             wait_s;
    logic             hold;
    logic [NSRC-1:0]  req_vec;

    assign req_vec = {req_run, req_exc, req_tmr, req_mem};

    ucseq_store #(.IDX_W(IDX_W), .DAT_W(UW_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (uc_we && state == ST_IDLE),
        .waddr (uc_addr),
        .wdata (uc_wdata),
        .raddr (idx_q),
        .rdata (rdata)
    );

    ucseq_arb #(.IDX_W(IDX_W), .NSRC(NSRC)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req_vec),
        .cfg_we  (cfg_we),
        .cfg_src (cfg_src),
        .cfg_idx (cfg_idx),
        .any     (any_req),
        .win     (win),
        .win_idx (win_idx)
    );

    ucseq_wsync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk (clk),
        .rst (rst),
        .d   (wait_in),
        .q   (wait_s)
    );

    assign word = uword_t'(rdata);
    assign hold = word.wen && wait_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            src_q  <= SRC_MEM;
            idx_q  <= '0;
            done   <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (uc_we && state == ST_RUN) wr_err <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (any_req) begin
                        state <= ST_RUN;
                        src_q <= win;
                        idx_q <= win_idx;
                    end
                end
                ST_RUN: begin
                    if (!hold) begin
                        if (word.last) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state == ST_RUN);
    assign active_src = src_q;
    assign seq_idx    = idx_q;
    assign cs_ph      = busy ? word.cs  : 4'hF;
    assign bs_ph      = busy ? word.bs  : 4'hF;
    assign gpo        = busy ? word.gpo : 4'h0;
    assign cs_line    = phase_bit(cs_ph, qsel);
    assign bs_line    = phase_bit(bs_ph, qsel);
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [1:0]       active_src,
    input logic [IDX_W-1:0] seq_idx,
    input logic [3:0]       cs_ph,
    input logic [3:0]       bs_ph,
    input logic             done,
    input logic             wr_err
);
    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_ph == 4'hF && bs_ph == 4'hF)); // R1

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (seq_idx == $past(seq_idx) || seq_idx == IDX_W'($past(seq_idx) + 1'b1))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> wr_err); // R9

    AST_SRC_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(active_src)); // R10
endmodule

bind ucode_bus_seq ucseq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .active_src (active_src),
    .seq_idx    (seq_idx),
    .cs_ph      (cs_ph),
    .bs_ph      (bs_ph),
    .done       (done),
    .wr_err     (wr_err)
);

// File: tb/sim_ucode_bus_seq.sv
`timescale 1ns/1ps
module sim_ucode_bus_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_mem = 0, req_tmr = 0, req_exc = 0, req_run = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_src = 0;
    logic [5:0]  cfg_idx = 0;
    logic        uc_we = 0;
    logic [5:0]  uc_addr = 0;
    logic [31:0] uc_wdata = 0;
    logic        wait_in = 0;
    logic [1:0]  qsel = 0;
    logic        busy, cs_line, bs_line, done, wr_err;
    logic [1:0]  active_src;
    logic [5:0]  seq_idx;
    logic [3:0]  cs_ph, bs_ph, gpo;

    int tests = 0, fails = 0;
    logic [31:0] img [64];
    logic [5:0]  starts [4];

    ucode_bus_seq u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] prio(input logic [3:0] m);
        if (m[2]) return 2'd2;
        if (m[3]) return 2'd3;
        if (m[1]) return 2'd1;
        return 2'd0;
    endfunction

    task automatic wr_word(input logic [5:0] a, input logic [31:0] d);
        uc_we = 1; uc_addr = a; uc_wdata = d;
        tick();
        uc_we = 0;
        img[a] = d;
    endtask

    task automatic wr_start(input int s, input logic [5:0] i);
        cfg_we = 1; cfg_src = 2'(s); cfg_idx = i;
        tick();
        cfg_we = 0;
        starts[s] = i;
    endtask

    task automatic set_req(input logic [3:0] m);
        {req_run, req_exc, req_tmr, req_mem} = m;
    endtask

    function automatic logic [31:0] mk(input logic [3:0] c, input logic [3:0] b, input logic [3:0] g,
                                       input logic w, input logic l);
        return {c, b, g, 18'd0, w, l};
    endfunction

    task automatic chk_word(input logic [5:0] ei);
        logic [31:0] w;
        w = img[ei];
        qsel = 2'($urandom);
        #0.1;
        chk("R5 index", 32'(seq_idx), 32'(ei));
        chk("R2 cs", 32'(cs_ph), 32'(w[31:28]));
        chk("R2 bs", 32'(bs_ph), 32'(w[27:24]));
        chk("R2 gpo", 32'(gpo), 32'(w[23:20]));
        chk("R11 cs_line", 32'(cs_line), 32'(w[31 - qsel]));
        chk("R11 bs_line", 32'(bs_line), 32'(w[27 - qsel]));
    endtask

    // start a sequence with request mask m and follow it to done (no stalls expected)
    task automatic run_seq(input logic [3:0] m, input string tag);
        logic [5:0] ei;
        logic [1:0] es;
        es = prio(m);
        ei = starts[es];
        set_req(m);
        tick();
        set_req(4'b0);
        chk({tag, " R3 busy"}, 32'(busy), 1);
        chk({tag, " R4 src"}, 32'(active_src), 32'(es));
        chk({tag, " R3 start"}, 32'(seq_idx), 32'(ei));
        for (int n = 0; n < 70; n++) begin
            logic l;
            chk_word(ei);
            chk("R10 src held", 32'(active_src), 32'(es));
            l = img[ei][0];
            tick();
            if (l) break;
            ei = ei + 1'b1;
        end
        chk("R6 busy low", 32'(busy), 0);
        chk("R6 done", 32'(done), 1);
        chk("R1 idle cs", 32'(cs_ph), 32'hF);
        tick();
        chk("R6 done single", 32'(done), 0);
        chk("R10 no restart", 32'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) img[i] = 32'd0;
        for (int s = 0; s < 4; s++) starts[s] = 6'(s * 16);
        void'($urandom(32'd1729));
        repeat (3) tick();
        rst = 0;
        tick();
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 wr_err", 32'(wr_err), 0);
        chk("R1 cs_ph", 32'(cs_ph), 32'hF);
        chk("R1 bs_ph", 32'(bs_ph), 32'hF);
        chk("R1 gpo", 32'(gpo), 0);
        chk("R1 cs_line", 32'(cs_line), 1);
        chk("R1 bs_line", 32'(bs_line), 1);

        // R3 reset start indices
        wr_word(6'd0,  mk(4'h1, 4'h2, 4'h3, 0, 1));
        wr_word(6'd16, mk(4'h4, 4'h5, 4'h6, 0, 1));
        wr_word(6'd32, mk(4'h7, 4'h8, 4'h9, 0, 0));
        wr_word(6'd33, mk(4'hA, 4'hB, 4'hC, 0, 1));
        wr_word(6'd48, mk(4'hD, 4'hE, 4'h5, 0, 1));
        run_seq(4'b0001, "R3 default mem");
        run_seq(4'b0010, "R3 default tmr");
        run_seq(4'b0100, "R3 default exc");
        run_seq(4'b1000, "R3 default run");

        // R4 priority ladder
        run_seq(4'b1111, "R4 all");
        run_seq(4'b1011, "R4 run>tmr>mem");
        run_seq(4'b0011, "R4 tmr>mem");
        run_seq(4'b0101, "R4 exc>mem");

        // R9 / R10: write and requests while busy
        wr_start(0, 6'd8);
        for (int i = 0; i < 5; i++) wr_word(6'(8 + i), mk(4'(i), 4'(~i), 4'(i + 3), 0, i == 4));
        set_req(4'b0001);
        tick();
        set_req(4'b0100);
        uc_we = 1; uc_addr = 6'd40; uc_wdata = 32'hFFF0_0003;
        chk("R10 busy", 32'(busy), 1);
        tick();
        uc_we = 0;
        chk("R9 wr_err set", 32'(wr_err), 1);
        chk("R10 src kept", 32'(active_src), 0);
        chk("R10 idx kept", 32'(seq_idx), 9);
        set_req(4'b0);
        repeat (4) tick();
        chk("R6 done mem seq", 32'(done), 1);
        tick();
        chk("R10 no late start", 32'(busy), 0);
        chk("R9 wr_err sticky", 32'(wr_err), 1);
        wr_start(2, 6'd40);
        wr_word(6'd41, mk(4'h3, 4'h3, 4'h3, 0, 1));
        img[40] = 32'd0;   // dropped write: word 40 still holds its reset value
        run_seq(4'b0100, "R9 old word");

        // R7 wait stall
        wr_start(3, 6'd20);
        wr_word(6'd20, mk(4'h6, 4'h9, 4'hA, 1, 0));
        wr_word(6'd21, mk(4'hC, 4'h3, 4'h5, 1, 1));
        wait_in = 1;
        tick(); tick();
        set_req(4'b1000);
        tick();
        set_req(4'b0);
        for (int c = 0; c <= 5; c++) begin
            chk_word(6'd20);
            chk("R7 held busy", 32'(busy), 1);
            if (c == 5) wait_in = 0;
            tick();
        end
        chk_word(6'd20);
        tick();
        chk_word(6'd20);
        tick();
        chk_word(6'd21);
        tick();
        chk("R7 done after stall", 32'(done), 1);
        tick();

        // R8 random: wait high, wait-enable clear
        wait_in = 1;
        for (int it = 0; it < 30; it++) begin
            if (it % 10 == 0) begin
                for (int a = 0; a < 64; a++)
                    wr_word(6'(a), mk(4'($urandom), 4'($urandom), 4'($urandom), 0,
                                      (a == 63) || ($urandom % 3 == 0)));
                for (int s = 0; s < 4; s++) wr_start(s, 6'($urandom));
            end
            run_seq(4'($urandom % 15 + 1), "R8 random");
        end
        wait_in = 0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule